// File: doc/BRIEF.md
# Wait-hold clock domain divider

This block divides a domain source clock by an integer ratio made of two phases. A high phase lasts for the wait count plus one input cycles, and a low phase lasts for the hold count plus one input cycles. The output period is therefore wait + hold + 2 input cycles. A configuration word is written through a simple write strobe and can be read back at all times. A bypass bit routes the input clock straight to the output.

A new ratio does not reach the counters directly. Software writes the wait and hold fields together with an update-request bit. That bit stays readable as one while the request is pending. Hardware clears it at the end of the output period in progress, which is when the new ratio takes over, so no truncated pulse appears. Bypass changes take effect at the same kind of period boundary. The parameter `CNT_W` sets the width of the count fields: 4 bits gives ratios 2 to 32, and 3 bits gives ratios 2 to 16.

To get a near-even duty cycle for a ratio R, program wait = R/2 - 1 and hold = R - wait - 2.

Top module: `clk_waithold_div`

## Requirements
- R1: With wait count W and hold count H in effect and bypass off, `div_out` is high for W+1 input cycles and then low for H+1 input cycles, repeating with a period of W+H+2.
- R2: The configuration word uses these positions: wait count in bits 19:16, hold count in bits 23:20, bypass in bit 24 and update request in bit 25. Each write loads the count and bypass fields, and `cfg_rdata` returns them in the next cycle. All other readback bits are zero.
- R3: After reset, `cfg_rdata` reads zero and the output divides by 2 (one cycle high, one cycle low).
- R4: A write with bit 25 set makes bit 25 read one from the next cycle. It stays one until the new counts are in effect and then returns to zero without further writes. A write with bit 25 clear changes the readback fields but leaves the running ratio unchanged.
- R5: With CNT_W = 3, bits 19 and 23 of a write are ignored and read back as zero. The largest ratio is then 16 (8 high, 8 low).
- R6: While bit 24 is in effect, `div_out` equals the input clock. Setting or clearing bit 24 takes effect only when the divided output starts a new period (its rising edge).
- R7: A pending ratio is applied only at the end of a complete output period. The period in progress when the request is written finishes with the old high and low lengths.
- R8: Ratio 32 (wait 15, hold 15) gives 16 high and 16 low. Ratio 7 programmed as wait 2, hold 3 gives 3 high and 4 low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Domain source clock to be divided |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | DATA_W | Configuration word to write |
| cfg_rdata | output | DATA_W | Readback of the configuration word and the pending flag |
| div_out | output | 1 | Divided clock, or clk while bypassed |

## Verification
The assertions assume that `wr_data` and `wr_en` change only away from the rising clock edge, and that reset is applied before the first write. They also assume that `CNT_W` is 3 or 4, so that every phase fits the bound the fields allow. The stimulus drives every input on the falling edge and samples on the falling edge. Bypass is observed just after a rising edge as well, where the passed-through clock is high. Requests that target the period boundary are timed from an observed rising or falling edge of the output, so each write lands in a known phase of the period.

// File: rtl/clk_waithold_div.sv
module clk_waithold_div #(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              div_out
);
  localparam int WAIT_LSB = 16;
  localparam int HOLD_LSB = 20;
  localparam int BYP_BIT  = 24;
  localparam int UPD_BIT  = 25;

  logic [CNT_W-1:0] wait_cfg, hold_cfg, wait_act, hold_act, cnt;
  logic             byp_cfg, byp_act, pend, q;

  wire [CNT_W-1:0] limit    = q ? wait_act : hold_act;
  wire             at_end   = (cnt == limit);
  wire             boundary = !q && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_cfg <= '0;
      hold_cfg <= '0;
      byp_cfg  <= 1'b0;
    end else if (wr_en) begin
      wait_cfg <= wr_data[WAIT_LSB +: CNT_W];
      hold_cfg <= wr_data[HOLD_LSB +: CNT_W];
      byp_cfg  <= wr_data[BYP_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        pend <= 1'b0;
    else if (wr_en && wr_data[UPD_BIT]) pend <= 1'b1;
    else if (boundary)                 pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q        <= 1'b1;
      cnt      <= '0;
      wait_act <= '0;
      hold_act <= '0;
      byp_act  <= 1'b0;
    end else begin
      cnt <= at_end ? '0 : cnt + 1'b1;
      if (at_end) q <= !q;
      if (boundary) begin
        byp_act <= byp_cfg;
        if (pend) begin
          wait_act <= wait_cfg;
          hold_act <= hold_cfg;
        end
      end
    end
  end

  always_comb begin
    cfg_rdata                     = '0;
    cfg_rdata[WAIT_LSB +: CNT_W]  = wait_cfg;
    cfg_rdata[HOLD_LSB +: CNT_W]  = hold_cfg;
    cfg_rdata[BYP_BIT]            = byp_cfg;
    cfg_rdata[UPD_BIT]            = pend;
  end

  assign div_out = byp_act ? clk : q;
endmodule

module clk_waithold_div_chk #(
  parameter int CNT_W  = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              q,
  input logic              byp_act
);
  logic       q_d;
  logic [7:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_d <= 1'b1;
      run <= '0;
    end else begin
      q_d <= q;
      if (q != q_d)      run <= 8'd1;
      else if (run != '1) run <= run + 8'd1;
    end
  end

  assert_upd_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[25]) |=> cfg_rdata[25]);

  assert_upd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[25] && !wr_en && q) |=> cfg_rdata[25]);

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_rdata[16 +: CNT_W] == $past(wr_data[16 +: CNT_W])) &&
              (cfg_rdata[20 +: CNT_W] == $past(wr_data[20 +: CNT_W])) &&
              (cfg_rdata[24] == $past(wr_data[24])));

  assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q != q_d) |-> (run <= (8'd1 << CNT_W)));

  assert_byp_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byp_act) |-> $rose(q));
endmodule

bind clk_waithold_div clk_waithold_div_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .cfg_rdata(cfg_rdata), .q(q), .byp_act(byp_act)
);

// File: tb/tb_clk_waithold_div.sv
module tb_clk_waithold_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_en_n = 1'b0;
  logic [31:0] wr_data = '0, wr_data_n = '0;
  logic [31:0] rdata, rdata_n;
  logic        dout, dout_n;
  int          tests = 0, fails = 0;

  always #5 clk = ~clk;

  clk_waithold_div #(.CNT_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_rdata(rdata), .div_out(dout));

  clk_waithold_div #(.CNT_W(3)) dut_n (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_n), .wr_data(wr_data_n),
    .cfg_rdata(rdata_n), .div_out(dout_n));

  function automatic logic o(input bit nar);
    return nar ? dout_n : dout;
  endfunction

  function automatic logic [31:0] cfg(input int w, input int h, input bit byp, input bit upd);
    return (32'(upd) << 25) | (32'(byp) << 24) | (32'(h) << 20) | (32'(w) << 16);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit nar, input logic [31:0] d);
    if (nar) begin wr_en_n = 1'b1; wr_data_n = d; end
    else     begin wr_en   = 1'b1; wr_data   = d; end
    @(negedge clk);
    wr_en = 1'b0; wr_en_n = 1'b0;
  endtask

  task automatic wait_rise(input bit nar);
    logic prev;
    prev = o(nar);
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if (!prev && o(nar)) break;
      prev = o(nar);
    end
  endtask

  task automatic run_len(input bit nar, input logic lvl, inout int n);
    for (int g = 0; g < 200; g++) begin
      @(negedge clk);
      if (o(nar) != lvl) break;
      n++;
    end
  endtask

  task automatic measure(input bit nar, output int hi, output int lo);
    wait_rise(nar);
    hi = 1; run_len(nar, 1'b1, hi);
    lo = 1; run_len(nar, 1'b0, lo);
  endtask

  task automatic wait_clear(input bit nar);
    for (int g = 0; g < 200; g++) begin
      if (!(nar ? rdata_n[25] : rdata[25])) break;
      @(negedge clk);
    end
  endtask

  task automatic apply(input bit nar, input int w, input int h);
    wr(nar, cfg(w, h, 1'b0, 1'b1));
    wait_clear(nar);
  endtask

  task automatic t_reset;
    int hi, lo;
    check("R3 readback", rdata, 0);
    check("R3 readback narrow", rdata_n, 0);
    measure(0, hi, lo);
    check("R3 high", hi, 1);
    check("R3 low", lo, 1);
  endtask

  task automatic t_basic;
    int hi, lo;
    wr(0, cfg(3, 2, 1'b0, 1'b1));
    check("R4 pending set", rdata[25], 1);
    check("R2 fields", rdata[24:16], 9'h023);
    check("R2 zero bits", {rdata[31:26], rdata[15:0]}, 0);
    wait_clear(0);
    check("R4 pending cleared", rdata[25], 0);
    measure(0, hi, lo);
    check("R1 high W=3", hi, 4);
    check("R1 low H=2", lo, 3);
  endtask

  task automatic t_extremes;
    int hi, lo;
    apply(0, 15, 15);
    measure(0, hi, lo);
    check("R8 ratio32 high", hi, 16);
    check("R8 ratio32 low", lo, 16);
    apply(0, 2, 3);
    measure(0, hi, lo);
    check("R8 ratio7 high", hi, 3);
    check("R8 ratio7 low", lo, 4);
    apply(0, 0, 5);
    measure(0, hi, lo);
    check("R1 high W=0", hi, 1);
    check("R1 low H=5", lo, 6);
  endtask

  task automatic t_no_update;
    int hi, lo;
    wr(0, cfg(7, 7, 1'b0, 1'b0));
    check("R4 fields without request", rdata[23:16], 8'h77);
    check("R4 no pending", rdata[25], 0);
    measure(0, hi, lo);
    check("R4 ratio kept high", hi, 1);
    check("R4 ratio kept low", lo, 6);
  endtask

  task automatic t_boundary;
    int hi, lo;
    apply(0, 15, 15);
    wait_rise(0);
    wr(0, cfg(1, 1, 1'b0, 1'b1));
    hi = 2; run_len(0, 1'b1, hi);
    check("R7 old high kept", hi, 16);
    check("R7 still pending", rdata[25], 1);
    lo = 1; run_len(0, 1'b0, lo);
    check("R7 old low kept", lo, 16);
    check("R7 cleared at boundary", rdata[25], 0);
    measure(0, hi, lo);
    check("R7 new high", hi, 2);
    check("R7 new low", lo, 2);
  endtask

  task automatic t_bypass;
    int hi, lo;
    logic lvl;
    apply(0, 15, 15);
    wait_rise(0);
    lo = 1; run_len(0, 1'b1, lo);
    wr(0, cfg(15, 15, 1'b1, 1'b0));
    check("R2 bypass bit", rdata[24], 1);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1; lvl = dout;
      check("R6 no bypass before boundary", lvl, 0);
    end
    repeat (20) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1; lvl = dout;
      check("R6 bypass follows clk high", lvl, 1);
      @(negedge clk); #1; lvl = dout;
      check("R6 bypass follows clk low", lvl, 0);
    end
    @(negedge clk);
    wr(0, cfg(15, 15, 1'b0, 1'b0));
    repeat (40) @(negedge clk);
    measure(0, hi, lo);
    check("R6 leave bypass high", hi, 16);
    check("R6 leave bypass low", lo, 16);
  endtask

  task automatic t_narrow;
    int hi, lo;
    wr(1, cfg(15, 15, 1'b0, 1'b1));
    check("R5 bits 19/23 ignored", rdata_n[23:16], 8'h77);
    wait_clear(1);
    measure(1, hi, lo);
    check("R5 max high", hi, 8);
    check("R5 max low", lo, 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_extremes();
    t_no_update();
    t_boundary();
    t_bypass();
    t_narrow();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule